// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits in the front end of a pipeline and assigns a taken or not-taken guess to a conditional branch as it is fetched or decoded. The guess needs no history. Its default is the sign of the branch displacement: a backward (negative) displacement is guessed taken and a forward one not taken. Branches that jump through a register have no displacement, so they default to not taken.

A hint bit in the 5-bit branch-options field lets the compiler invert that default for a single instruction. Options codes that describe an unconditional branch are always guessed taken, and the hint cannot change them. Codes that use the hint position for another meaning are never inverted.

The result is registered. It appears on the outputs one cycle after a valid strobe, together with a flag that shows whether the hint inverted the default. A flush input clears the registered result.

Top module: `staticBranchPredictor`

## Requirements
- R1: After reset, `validOut`, `predTaken` and `predReversed` are all 0.
- R2: For the relative form (`formIn` = 0), when the hint does not apply, a sign of 1 predicts taken and a sign of 0 predicts not taken.
- R3: For the absolute form (`formIn` = 1), the default follows the same sign rule as the relative form.
- R4: For the register form (`formIn` = 2), and for the spare code 3, the default is not taken and `signIn` has no effect.
- R5: When `optIn[0]` is 0 (the condition is tested), `optIn[4]` is a hint. A hint of 1 inverts the default and sets `predReversed`. A hint of 0 leaves the default unchanged and clears `predReversed`.
- R6: When `optIn[0]` and `optIn[1]` are both 1 (branch always), the prediction is taken and `predReversed` is 0, whatever the values of `optIn[4]`, `signIn` and `formIn`.
- R7: When `optIn[0]` is 1 and `optIn[1]` is 0 (only the counter is tested), `optIn[4]` is not a hint. The default is output unchanged and `predReversed` is 0.
- R8: The outputs update on the first rising clock edge after `validIn` is sampled high. `validOut` is 1 for exactly the cycles that follow a cycle with a valid strobe.
- R9: In a cycle after `validIn` was sampled low, `validOut` is 0, and `predTaken` and `predReversed` keep their last values.
- R10: A sampled `flushIn` clears `validOut`, `predTaken` and `predReversed` at the next edge. It takes priority over a `validIn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| validIn | input | 1 | A branch is presented this cycle |
| formIn | input | 2 | Target form: 0 relative, 1 absolute, 2 register, 3 spare |
| signIn | input | 1 | Sign bit of the displacement |
| optIn | input | 5 | Branch-options field: bit 0 ignore condition, bit 1 ignore counter, bit 4 hint |
| flushIn | input | 1 | Clear the registered result |
| validOut | output | 1 | Registered prediction is valid |
| predTaken | output | 1 | Registered prediction, 1 = taken |
| predReversed | output | 1 | Registered flag, 1 = the hint inverted the default |

## Verification
The bench targets the places where the hint must be refused. A design that honoured the hint on a branch-always code would predict not taken, or would raise the reversed flag, on an unconditional jump. A design that treated bit 4 as a hint on a counter-only code would invert a backward loop branch. Register-form branches arrive with the sign input set, which catches a design that lets a stale sign decide the default. The bench also checks a flush that arrives together with a valid strobe, and idle cycles with changing inputs. A wrong flush priority would leave a stale valid prediction, and a missing hold would let the prediction wander while the result is not valid.

// File: rtl/staticBpPkg.sv
package staticBpPkg;

  typedef enum logic [1:0] {
    FORM_REL  = 2'd0,
    FORM_ABS  = 2'd1,
    FORM_REG  = 2'd2,
    FORM_RSVD = 2'd3
  } brForm_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } bpStrobe_t;

endpackage

// File: rtl/bpControl.sv
module bpControl
  import staticBpPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      validIn,
  input  logic      flushIn,
  output bpStrobe_t strobe,
  output logic      validQ
);

  always_comb begin
    strobe.clear   = flushIn;
    strobe.capture = validIn && !flushIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             validQ <= 1'b0;
    else if (strobe.clear) validQ <= 1'b0;
    else                   validQ <= strobe.capture;
  end

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !flushIn) |=> validQ);

  assert_idle_invalid_R9: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validQ);

  assert_flush_invalid_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> !validQ);

endmodule

// File: rtl/bpDatapath.sv
module bpDatapath
  import staticBpPkg::*;
#(
  parameter int OPT_W       = 5,
  parameter int HINT_BIT    = 4,
  parameter int CONDIGN_BIT = 0,
  parameter int CTRIGN_BIT  = 1,
  parameter bit REG_DEFAULT = 1'b0
)(
  input  logic             clk,
  input  logic             rstN,
  input  bpStrobe_t        strobe,
  input  logic [1:0]       formIn,
  input  logic             signIn,
  input  logic [OPT_W-1:0] optIn,
  output logic             predQ,
  output logic             revQ
);

  brForm_e form;
  logic    condIgnored;
  logic    ctrIgnored;
  logic    isAlways;
  logic    hintAllowed;
  logic    defaultTaken;
  logic    doReverse;
  logic    predNext;

  assign form        = brForm_e'(formIn);
  assign condIgnored = optIn[CONDIGN_BIT];
  assign ctrIgnored  = optIn[CTRIGN_BIT];
  assign isAlways    = condIgnored && ctrIgnored;
  // The hint position only carries a hint while the condition is tested.
  assign hintAllowed = !condIgnored;

  always_comb begin
    unique case (form)
      FORM_REL, FORM_ABS: defaultTaken = signIn;
      default:            defaultTaken = REG_DEFAULT;
    endcase
  end

  assign doReverse = hintAllowed && optIn[HINT_BIT];
  assign predNext  = isAlways ? 1'b1 : (defaultTaken ^ doReverse);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      predQ <= 1'b0;
      revQ  <= 1'b0;
    end else if (strobe.capture) begin
      predQ <= predNext;
      revQ  <= doReverse;
    end
  end

  assert_always_taken_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && optIn[CONDIGN_BIT] && optIn[CTRIGN_BIT]) |=> (predQ && !revQ));

  assert_counter_no_rev_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && optIn[CONDIGN_BIT]) |=> !revQ);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !strobe.clear) |=> ($stable(predQ) && $stable(revQ)));

  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (!predQ && !revQ));

endmodule

// File: rtl/staticBranchPredictor.sv
module staticBranchPredictor
  import staticBpPkg::*;
#(
  parameter int OPT_W = 5
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [1:0]       formIn,
  input  logic             signIn,
  input  logic [OPT_W-1:0] optIn,
  input  logic             flushIn,
  output logic             validOut,
  output logic             predTaken,
  output logic             predReversed
);

  bpStrobe_t strobe;

  bpControl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .validIn(validIn),
    .flushIn(flushIn),
    .strobe (strobe),
    .validQ (validOut)
  );

  bpDatapath #(.OPT_W(OPT_W)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .formIn(formIn),
    .signIn(signIn),
    .optIn (optIn),
    .predQ (predTaken),
    .revQ  (predReversed)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!validOut && !predTaken && !predReversed));

endmodule

// File: tb/staticBranchPredictor_test.sv
module staticBranchPredictor_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       validIn;
  logic [1:0] formIn;
  logic       signIn;
  logic [4:0] optIn;
  logic       flushIn;
  logic       validOut;
  logic       predTaken;
  logic       predReversed;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  staticBranchPredictor uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .formIn(formIn), .signIn(signIn),
    .optIn(optIn), .flushIn(flushIn), .validOut(validOut), .predTaken(predTaken),
    .predReversed(predReversed)
  );

  // Vector layout: form[9:8] sign[7] opt[6:2] expPred[1] expRev[0]
  localparam int NVEC = 16;
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 5'b00000, 1'b1, 1'b0},  // R2 backward, taken
    {2'd0, 1'b0, 5'b00000, 1'b0, 1'b0},  // R2 forward, not taken
    {2'd0, 1'b1, 5'b10000, 1'b0, 1'b1},  // R5 hint inverts taken
    {2'd0, 1'b0, 5'b10000, 1'b1, 1'b1},  // R5 hint inverts not taken
    {2'd1, 1'b1, 5'b00000, 1'b1, 1'b0},  // R3 absolute high
    {2'd1, 1'b0, 5'b10100, 1'b1, 1'b1},  // R3 absolute low plus hint
    {2'd1, 1'b0, 5'b00000, 1'b0, 1'b0},  // R3 absolute low
    {2'd2, 1'b1, 5'b00000, 1'b0, 1'b0},  // R4 register, sign ignored
    {2'd2, 1'b0, 5'b10000, 1'b1, 1'b1},  // R4 register plus hint
    {2'd0, 1'b0, 5'b00011, 1'b1, 1'b0},  // R6 always
    {2'd0, 1'b0, 5'b10011, 1'b1, 1'b0},  // R6 always, hint ignored
    {2'd2, 1'b0, 5'b10011, 1'b1, 1'b0},  // R6 always, register form
    {2'd0, 1'b1, 5'b10010, 1'b0, 1'b1},  // R5 condition tested
    {2'd0, 1'b1, 5'b10001, 1'b1, 1'b0},  // R7 counter only
    {2'd0, 1'b0, 5'b10001, 1'b0, 1'b0},  // R7 counter only, forward
    {2'd3, 1'b1, 5'b10000, 1'b1, 1'b1}   // R4 spare code
  };

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,pred,rev} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [1:0] f, logic s, logic [4:0] o, logic fl);
    validIn = v; formIn = f; signIn = s; optIn = o; flushIn = fl;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(1'b1, 2'd0, 1'b1, 5'b00011, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1", {validOut, predTaken, predReversed}, 3'b000);
    rstN = 1'b1;
    drive(1'b0, 2'd0, 1'b0, 5'b0, 1'b0);
    @(negedge clk);
    chk("R1", {validOut, predTaken, predReversed}, 3'b000);

    // Table walk, one branch per cycle.
    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VEC[i][9:8], VEC[i][7], VEC[i][6:2], 1'b0);
      @(negedge clk);
      chk($sformatf("R8 vec%0d", i), {validOut, predTaken, predReversed},
          {1'b1, VEC[i][1:0]});
    end

    // R9: idle with changing inputs holds the last prediction (taken, reversed).
    drive(1'b1, 2'd0, 1'b0, 5'b10000, 1'b0);
    @(negedge clk);
    chk("R5", {validOut, predTaken, predReversed}, 3'b111);
    drive(1'b0, 2'd0, 1'b1, 5'b00000, 1'b0);
    @(negedge clk);
    chk("R9", {validOut, predTaken, predReversed}, 3'b011);
    drive(1'b0, 2'd2, 1'b0, 5'b00011, 1'b0);
    @(negedge clk);
    chk("R9", {validOut, predTaken, predReversed}, 3'b011);

    // R10: a flush alone clears everything.
    drive(1'b0, 2'd0, 1'b0, 5'b0, 1'b1);
    @(negedge clk);
    chk("R10", {validOut, predTaken, predReversed}, 3'b000);

    // R10: a flush beats a valid strobe in the same cycle.
    drive(1'b1, 2'd0, 1'b1, 5'b00000, 1'b0);
    @(negedge clk);
    chk("R2", {validOut, predTaken, predReversed}, 3'b110);
    drive(1'b1, 2'd0, 1'b0, 5'b10000, 1'b1);
    @(negedge clk);
    chk("R10", {validOut, predTaken, predReversed}, 3'b000);

    // R8: the result appears one edge after the strobe, not earlier.
    drive(1'b0, 2'd0, 1'b0, 5'b0, 1'b0);
    @(negedge clk);
    drive(1'b1, 2'd1, 1'b1, 5'b00000, 1'b0);
    @(posedge clk);
    #1;
    chk("R8", {validOut, predTaken, predReversed}, 3'b110);
    drive(1'b0, 2'd1, 1'b1, 5'b00000, 1'b0);
    @(negedge clk);
    chk("R8", {validOut, predTaken, predReversed}, 3'b110);
    @(negedge clk);
    chk("R9", {validOut, predTaken, predReversed}, 3'b010);

    // R1: reset in the middle of a run.
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", {validOut, predTaken, predReversed}, 3'b000);
    rstN = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule